// File: doc/BRIEF.md
# Debug Trigger State Sequencer

This block is the event-ordering core of an on-chip debug unit. Three comparator channels (0, 1, 2) each deliver a one-cycle match pulse. The block walks through three intermediate states toward a final trigger state. Each intermediate state owns a 4-bit selection code. The code for the state the sequencer is in decides which channel moves it where. When more than one channel fires in the same cycle, a fixed priority picks the winner.

Arming the block starts a debug session in State1 and clears a sticky per-channel record of which channels have fired. That record stays intact after the session ends, so it can be examined later. It is read through an 8-bit data port gated by a 2-bit bank selector. Reaching the final state produces a one-cycle trigger pulse, after which the sequencer waits for a new arm or a disarm.

Top module: `dbg_trig_seq`

## Requirements
- R1: After reset the state output reads 0 (idle), the trigger output is low, the readback port is zero for every bank value, and all three selection codes are 0000.
- R2: An arm write with value 1 makes the next state State1 and clears all match flags, even if matches arrive in that same cycle. State encoding: idle 0, State1 1, State2 2, State3 3, final 4.
- R3: An arm write with value 0 returns the sequencer to idle. While idle, match pulses change neither the state nor the flags.
- R4: A selection code routes named channels to one of three targets: "low alternate", "high alternate" or final. The low alternate is the lowest-numbered intermediate state other than the current one, and the high alternate is the highest such state. In State3 these are State1 and State2. Routes per code: 0001 ch2 high, ch1 final. 0010 ch1 low, ch0 final. 0011 ch2 low, ch1 final. 0100 ch1 high. 0101 ch1 final. 0110 ch2 high, ch0 final. 0111 ch0 final. 1010 ch1 and ch2 low, ch0 final. 1101 ch0 low, ch1 and ch2 final. 1110 ch0 high, ch2 final.
- R5: Code 0000 and the reserved codes 1000, 1001, 1011, 1100 and 1111 cause no transition. A match on a channel the active code does not route leaves the state unchanged.
- R6: Among simultaneous routed matches, any match routed to final wins. Otherwise the lowest-numbered routed channel wins.
- R7: The trigger output is high for exactly one cycle, the first cycle in which the state output reads final.
- R8: Once final, the sequencer stays final and ignores matches until an arm write of either value.
- R9: While the state is State1, State2 or State3, a match on channel k sets flag k. Flags are cleared only by an arm write with value 1, and a set flag never blocks another channel's flag.
- R10: When the bank selector equals 11, the readback port carries the flags in bits 2:0 (bit k is channel k) and zeros in bits 7:3. For any other bank value it reads zero.
- R11: A code write with selector 1, 2 or 3 loads the code of State1, State2 or State3, and the new code takes effect from the next cycle. A write with selector 0 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm_wr | input | 1 | Arm bit write strobe |
| arm_val | input | 1 | Value written to the arm bit (1 arm, 0 disarm) |
| match_i | input | 3 | Comparator match pulses, bit k for channel k |
| code_we | input | 1 | Selection code write strobe |
| code_sel | input | 2 | Which state's code to write (1..3) |
| code_wdata | input | 4 | Selection code value |
| bank_sel | input | 2 | Register window bank selector |
| rd_data | output | 8 | Readback data (flags in bank 11) |
| state_o | output | 3 | Current sequencer state |
| trig_o | output | 1 | One-cycle final-state trigger |

## Verification
The bench uses the default parameters: an 8-bit readback port and flag bank 11. With these, the unused upper readback bits and the bank gating can be observed directly at the port. A vector table drives the sequencer into State3 for every one of the sixteen codes and applies single and simultaneous match patterns, which reaches every route and the final-first priority. Directed sequences check the alternate-state mapping from State1 and State2, flag retention across a disarm, arming in the same cycle as a match, and the final-state hold.

// File: rtl/dbg_trig_seq_pkg.sv
package dbg_trig_seq_pkg;

  localparam int NUM_CH = 3;
  localparam int CODE_W = 4;
  localparam int ST_W   = 3;

  typedef enum logic [ST_W-1:0] {
    ST_IDLE = 3'd0,
    ST_S1   = 3'd1,
    ST_S2   = 3'd2,
    ST_S3   = 3'd3,
    ST_FIN  = 3'd4
  } seq_state_e;

  // route target named by a selection code
  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_LO   = 2'd1,
    TGT_HI   = 2'd2,
    TGT_FIN  = 2'd3
  } seq_tgt_e;

endpackage

// File: rtl/dbg_seq_code_regs.sv
module dbg_seq_code_regs
  import dbg_trig_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              code_we,
  input  logic [1:0]        code_sel,
  input  logic [CODE_W-1:0] code_wdata,
  input  seq_state_e        state,
  output logic [CODE_W-1:0] cur_code
);

  localparam int NUM_ST = 3;

  logic [CODE_W-1:0] code_q [1:NUM_ST];

  for (genvar g = 1; g <= NUM_ST; g++) begin : g_code
    logic ld_en;
    assign ld_en = code_we && (code_sel == 2'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        code_q[g] <= '0;
      end else if (ld_en) begin
        code_q[g] <= code_wdata;
      end
    end
  end

  always_comb begin
    unique case (state)
      ST_S1:   cur_code = code_q[1];
      ST_S2:   cur_code = code_q[2];
      ST_S3:   cur_code = code_q[3];
      default: cur_code = '0;
    endcase
  end

endmodule

// File: rtl/dbg_seq_sel_decode.sv
module dbg_seq_sel_decode
  import dbg_trig_seq_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  input  logic [NUM_CH-1:0] match,
  output logic              hit,
  output seq_tgt_e          tgt
);

  seq_tgt_e route [NUM_CH];

  // per-channel routing for each code; unlisted codes route nothing
  always_comb begin
    for (int c = 0; c < NUM_CH; c++) route[c] = TGT_NONE;
    unique case (code)
      4'b0001: begin route[2] = TGT_HI;  route[1] = TGT_FIN; end
      4'b0010: begin route[1] = TGT_LO;  route[0] = TGT_FIN; end
      4'b0011: begin route[2] = TGT_LO;  route[1] = TGT_FIN; end
      4'b0100: route[1] = TGT_HI;
      4'b0101: route[1] = TGT_FIN;
      4'b0110: begin route[2] = TGT_HI;  route[0] = TGT_FIN; end
      4'b0111: route[0] = TGT_FIN;
      4'b1010: begin
        route[1] = TGT_LO;  route[2] = TGT_LO;  route[0] = TGT_FIN;
      end
      4'b1101: begin
        route[0] = TGT_LO;  route[1] = TGT_FIN; route[2] = TGT_FIN;
      end
      4'b1110: begin route[0] = TGT_HI;  route[2] = TGT_FIN; end
      default: ;
    endcase
  end

  // final-bound match first, then lowest channel
  always_comb begin
    logic fin_any;
    fin_any = 1'b0;
    hit     = 1'b0;
    tgt     = TGT_NONE;
    for (int c = NUM_CH - 1; c >= 0; c--) begin
      if (match[c] && route[c] != TGT_NONE) begin
        hit = 1'b1;
        tgt = route[c];
      end
      if (match[c] && route[c] == TGT_FIN) fin_any = 1'b1;
    end
    if (fin_any) tgt = TGT_FIN;
  end

endmodule

// File: rtl/dbg_seq_flags.sv
module dbg_seq_flags
  import dbg_trig_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              active,
  input  logic [NUM_CH-1:0] match,
  output logic [NUM_CH-1:0] flags
);

  logic [NUM_CH-1:0] flags_d;
  logic              flags_en;

  assign flags_en = clr || active;

  always_comb begin
    if (clr) flags_d = '0;
    else     flags_d = flags | match;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
    end else if (flags_en) begin
      flags <= flags_d;
    end
  end

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((flags & $past(flags)) == $past(flags))) else $error("sticky"); // R9
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (flags == '0)) else $error("clear"); // R2
  AST_FLAG_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !clr) |=> $stable(flags)) else $error("quiet"); // R3

endmodule

// File: rtl/dbg_seq_fsm.sv
module dbg_seq_fsm
  import dbg_trig_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     arm_wr,
  input  logic     arm_val,
  input  logic     hit,
  input  seq_tgt_e tgt,
  output seq_state_e state,
  output logic     active,
  output logic     trig
);

  seq_state_e state_d;
  seq_state_e alt_lo;
  seq_state_e alt_hi;
  logic       trig_d;

  assign active = (state == ST_S1) || (state == ST_S2) || (state == ST_S3);
  assign alt_lo = (state == ST_S1) ? ST_S2 : ST_S1;
  assign alt_hi = (state == ST_S3) ? ST_S2 : ST_S3;

  always_comb begin
    state_d = state;
    if (arm_wr) begin
      state_d = arm_val ? ST_S1 : ST_IDLE;
    end else if (active && hit) begin
      unique case (tgt)
        TGT_LO:  state_d = alt_lo;
        TGT_HI:  state_d = alt_hi;
        TGT_FIN: state_d = ST_FIN;
        default: state_d = state;
      endcase
    end
    trig_d = (state_d == ST_FIN) && (state != ST_FIN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      trig  <= 1'b0;
    end else begin
      state <= state_d;
      trig  <= trig_d;
    end
  end

  AST_ARM_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_wr && arm_val) |=> (state == ST_S1)) else $error("arm"); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !arm_wr) |=> (state == ST_IDLE)) else $error("idle"); // R3
  AST_TRIG_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> !trig) else $error("trig"); // R7
  AST_TRIG_AT_FIN: assert property (@(posedge clk) disable iff (!rst_n)
    trig |-> (state == ST_FIN)) else $error("trigfin"); // R7
  AST_FINAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FIN && !arm_wr) |=> (state == ST_FIN)) else $error("hold"); // R8

endmodule

// File: rtl/dbg_trig_seq.sv
module dbg_trig_seq
  import dbg_trig_seq_pkg::*;
#(
  parameter int                RD_W      = 8,
  parameter int                BANK_W    = 2,
  parameter logic [BANK_W-1:0] FLAG_BANK = 2'b11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm_wr,
  input  logic              arm_val,
  input  logic [NUM_CH-1:0] match_i,
  input  logic              code_we,
  input  logic [1:0]        code_sel,
  input  logic [CODE_W-1:0] code_wdata,
  input  logic [BANK_W-1:0] bank_sel,
  output logic [RD_W-1:0]   rd_data,
  output logic [ST_W-1:0]   state_o,
  output logic              trig_o
);

  logic [1:0]        rst_sync_q;
  logic              rst_ni;
  seq_state_e        state;
  logic              active;
  logic              hit;
  seq_tgt_e          tgt;
  logic [CODE_W-1:0] cur_code;
  logic [NUM_CH-1:0] flags;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  dbg_seq_code_regs u_codes (
    .clk        (clk),
    .rst_n      (rst_ni),
    .code_we    (code_we),
    .code_sel   (code_sel),
    .code_wdata (code_wdata),
    .state      (state),
    .cur_code   (cur_code)
  );

  dbg_seq_sel_decode u_dec (
    .code  (cur_code),
    .match (match_i),
    .hit   (hit),
    .tgt   (tgt)
  );

  dbg_seq_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_ni),
    .arm_wr  (arm_wr),
    .arm_val (arm_val),
    .hit     (hit),
    .tgt     (tgt),
    .state   (state),
    .active  (active),
    .trig    (trig_o)
  );

  dbg_seq_flags u_flags (
    .clk    (clk),
    .rst_n  (rst_ni),
    .clr    (arm_wr && arm_val),
    .active (active && !arm_wr),
    .match  (match_i),
    .flags  (flags)
  );

  assign state_o = state;

  always_comb begin
    rd_data = '0;
    if (bank_sel == FLAG_BANK) rd_data[NUM_CH-1:0] = flags;
  end

  AST_RD_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_ni)
    rd_data[RD_W-1:NUM_CH] == '0) else $error("upper"); // R10
  AST_RD_BANK_GATE: assert property (@(posedge clk) disable iff (!rst_ni)
    (bank_sel != FLAG_BANK) |-> (rd_data == '0)) else $error("bank"); // R10

endmodule

// File: tb/dbg_trig_seq_tb.sv
module dbg_trig_seq_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       arm_wr, arm_val, code_we;
  logic [2:0] match_i;
  logic [1:0] code_sel, bank_sel;
  logic [3:0] code_wdata;
  logic [7:0] rd_data;
  logic [2:0] state_o;
  logic       trig_o;

  int n_checks = 0;
  int n_errors = 0;

  always #5 clk = ~clk;

  dbg_trig_seq u_dut (
    .clk(clk), .rst_n(rst_n), .arm_wr(arm_wr), .arm_val(arm_val),
    .match_i(match_i), .code_we(code_we), .code_sel(code_sel),
    .code_wdata(code_wdata), .bank_sel(bank_sel), .rd_data(rd_data),
    .state_o(state_o), .trig_o(trig_o)
  );

  // {code, match, expected state after the match, starting in State3}
  localparam int NV = 28;
  localparam logic [9:0] VEC [NV] = '{
    {4'b0001, 3'b100, 3'd2}, {4'b0001, 3'b010, 3'd4},
    {4'b0001, 3'b110, 3'd4}, {4'b0001, 3'b001, 3'd3},
    {4'b0010, 3'b010, 3'd1}, {4'b0010, 3'b011, 3'd4},
    {4'b0011, 3'b100, 3'd1}, {4'b0011, 3'b110, 3'd4},
    {4'b0100, 3'b010, 3'd2}, {4'b0100, 3'b101, 3'd3},
    {4'b0101, 3'b010, 3'd4}, {4'b0101, 3'b101, 3'd3},
    {4'b0110, 3'b100, 3'd2}, {4'b0110, 3'b101, 3'd4},
    {4'b0111, 3'b001, 3'd4}, {4'b0111, 3'b110, 3'd3},
    {4'b1010, 3'b110, 3'd1}, {4'b1010, 3'b111, 3'd4},
    {4'b1101, 3'b001, 3'd1}, {4'b1101, 3'b101, 3'd4},
    {4'b1110, 3'b001, 3'd2}, {4'b1110, 3'b101, 3'd4},
    {4'b0000, 3'b111, 3'd3}, {4'b1000, 3'b111, 3'd3},
    {4'b1001, 3'b111, 3'd3}, {4'b1011, 3'b111, 3'd3},
    {4'b1100, 3'b111, 3'd3}, {4'b1111, 3'b111, 3'd3}
  };

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic arm(input logic v);
    arm_wr = 1'b1; arm_val = v;
    @(negedge clk);
    arm_wr = 1'b0; arm_val = 1'b0;
  endtask

  task automatic wr_code(input logic [1:0] s, input logic [3:0] c);
    code_we = 1'b1; code_sel = s; code_wdata = c;
    @(negedge clk);
    code_we = 1'b0; code_sel = 2'd0; code_wdata = 4'd0;
  endtask

  task automatic pulse(input logic [2:0] m);
    match_i = m;
    @(negedge clk);
    match_i = 3'b000;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; arm_wr = 1'b0; arm_val = 1'b0; code_we = 1'b0;
    match_i = 3'b000; code_sel = 2'd0; code_wdata = 4'd0; bank_sel = 2'b11;
    repeat (3) @(negedge clk);
    check("R1 state", int'(state_o), 0);
    check("R1 trig", int'(trig_o), 0);
    check("R1 rd bank11", int'(rd_data), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    bank_sel = 2'b00;
    check("R1 rd bank00", int'(rd_data), 0);
    bank_sel = 2'b11;
    // codes reset to 0000: no transition after arming
    arm(1'b1);
    pulse(3'b111);
    check("R1_R5 reset code", int'(state_o), 1);

    // vector table in State3
    for (int i = 0; i < NV; i++) begin
      logic [3:0] vc;
      logic [2:0] vm;
      int         ve;
      vc = VEC[i][9:6]; vm = VEC[i][5:3]; ve = int'(VEC[i][2:0]);
      arm(1'b1);
      wr_code(2'd1, 4'b0100);
      wr_code(2'd3, vc);
      pulse(3'b010);
      check("R4 reach State3", int'(state_o), 3);
      pulse(vm);
      check("R4_R5_R6 route", int'(state_o), ve);
      check("R7 trig on entry", int'(trig_o), (ve == 4) ? 1 : 0);
    end

    // R4 alternates from State1 and State2
    arm(1'b1);
    wr_code(2'd1, 4'b0001);
    pulse(3'b100);
    check("R4 S1 high alt", int'(state_o), 3);
    arm(1'b1);
    wr_code(2'd1, 4'b0010);
    pulse(3'b010);
    check("R4 S1 low alt", int'(state_o), 2);
    wr_code(2'd2, 4'b0100);
    pulse(3'b010);
    check("R4 S2 high alt", int'(state_o), 3);
    arm(1'b1);
    pulse(3'b010);
    wr_code(2'd2, 4'b0010);
    pulse(3'b010);
    check("R4 S2 low alt", int'(state_o), 1);

    // R11 selector 0 ignored
    arm(1'b1);
    wr_code(2'd1, 4'b0000);
    wr_code(2'd0, 4'b0101);
    pulse(3'b010);
    check("R11 sel0 ignored", int'(state_o), 1);
    wr_code(2'd1, 4'b0101);
    pulse(3'b010);
    check("R11 code load", int'(state_o), 4);

    // R7 R8 final hold
    check("R7 trig one cycle", int'(trig_o), 1);
    @(negedge clk);
    check("R7 trig drops", int'(trig_o), 0);
    pulse(3'b111);
    check("R8 final hold", int'(state_o), 4);
    check("R8 no retrigger", int'(trig_o), 0);

    // R9 R10 flags
    arm(1'b1);
    wr_code(2'd1, 4'b0000);
    check("R2 flags cleared", int'(rd_data), 0);
    pulse(3'b001);
    check("R10 flag ch0", int'(rd_data), 1);
    pulse(3'b100);
    check("R9 flag independent", int'(rd_data), 5);
    pulse(3'b001);
    check("R9 flag unchanged", int'(rd_data), 5);
    bank_sel = 2'b10;
    #1 check("R10 other bank", int'(rd_data), 0);
    bank_sel = 2'b11;
    arm(1'b0);
    check("R3 disarm idle", int'(state_o), 0);
    check("R9 retained", int'(rd_data), 5);
    pulse(3'b010);
    check("R3 idle state", int'(state_o), 0);
    check("R3 idle flags", int'(rd_data), 5);

    // R2 arm with simultaneous match
    match_i = 3'b111;
    arm(1'b1);
    match_i = 3'b000;
    check("R2 arm state", int'(state_o), 1);
    check("R2 arm clears", int'(rd_data), 0);

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule